// File: doc/BRIEF.md
# Direct-Mapped Translation Cache with Walk Refill

This block keeps recently used address translations so that most requests need no page table access. A requester presents a virtual address. The block splits the virtual page number into a set index (low bits) and a tag (high bits). The page offset is not used to select an entry; it is copied straight into the physical address that comes back. A request that finds a valid entry with a matching tag returns the translation one cycle later.

A request that misses raises a walk request toward an external table walker and holds it until the walker reports completion. The walker returns the final-level entry, which carries the physical page number and a fault flag. That result goes back to the requester. If no fault is reported, the result is also written into the indexed set, replacing whatever was there.

A global flush input invalidates every entry in a single cycle. A flush also takes precedence over any refill or lookup in the same cycle.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid: `req_ready_o`=1, `resp_valid_o`=0, `walk_req_o`=0, and the first lookup of any page misses.
- R2: A request is taken only while `req_ready_o` is 1. `req_ready_o` is 0 whenever `walk_req_o` is 1.
- R3: A request that hits gives `resp_valid_o`=1 and `resp_hit_o`=1 in the cycle after it is taken, with no walk request. `resp_paddr_o` is {stored page number, offset bits [11:0] of the request}. The offset takes no part in the match.
- R4: A request that misses raises `walk_req_o` in the cycle after it is taken, with `walk_vpn_o` equal to address bits [31:12]. Both hold unchanged until `walk_done_i` is sampled high.
- R5: When `walk_done_i` is sampled high with `walk_fault_i`=0, the next cycle gives `resp_valid_o`=1, `resp_hit_o`=0, `resp_fault_o`=0 and `resp_paddr_o`={`walk_ppn_i`, request offset}, and `walk_req_o` falls. The entry is installed, so a later lookup of that page hits.
- R6: When the walk reports `walk_fault_i`=1, the response carries `resp_fault_o`=1 and `resp_hit_o`=0. Nothing is installed, so a repeated lookup misses again.
- R7: The set index is virtual page number bits [3:0] (16 sets, one entry each). A refill replaces the entry in its set, so an older page with the same index but a different tag then misses. Entries in other sets are unaffected.
- R8: One cycle of `flush_i` invalidates every entry, so each later lookup misses until it is refilled.
- R9: If a flush and a walk completion fall in the same cycle, the response is still delivered with the walked page number, but the entry is not installed.
- R10: A request taken in a flush cycle is treated as a miss and raises a walk request, even if its entry was valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Lookup request strobe |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Block can take a request |
| resp_valid_o | output | 1 | Response pulse |
| resp_hit_o | output | 1 | Response came from a stored entry |
| resp_fault_o | output | 1 | Walk reported a fault |
| resp_paddr_o | output | 32 | Translated physical address |
| walk_req_o | output | 1 | Table walk wanted, held until done |
| walk_vpn_o | output | 20 | Page number to walk |
| walk_done_i | input | 1 | Walker result valid |
| walk_fault_i | input | 1 | Walker result is a fault |
| walk_ppn_i | input | 20 | Final-level physical page number |

## Verification
Flush can land in the same cycle as a refill, or in the same cycle as a lookup. Both cases are set up on purpose. In the first, the bench raises `flush_i` in the cycle it returns the walk result. It then checks that the response carries the walked page and that a repeat lookup of the same page walks again. In the second, the bench issues a request for a page known to be resident, with `flush_i` raised in the same cycle. It then checks that a walk request appears and that no hit response does.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
   typedef enum logic [0:0] {
      XC_IDLE = 1'b0,
      XC_WALK = 1'b1
   } xc_state_e;
endpackage

// File: rtl/xlat_cache_array.sv
module xlat_cache_array #(
   parameter int SETS  = 16,
   parameter int TAG_W = 16,
   parameter int PPN_W = 20,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   output logic [PPN_W-1:0] rd_ppn,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PPN_W-1:0] wr_ppn
);
   logic [SETS-1:0]  valid_q;
   logic [TAG_W-1:0] tag_q [SETS];
   logic [PPN_W-1:0] ppn_q [SETS];

   generate
      if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
         $error("xlat_cache_array: SETS must be a power of two, at least 2");
      end
      for (genvar s = 0; s < SETS; s++) begin : g_set
         logic sel;
         assign sel = wr_en && (wr_idx == IDX_W'(s));

         always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
               valid_q[s] <= 1'b0;
            end else if (sel) begin
               valid_q[s] <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (sel && !flush) begin
               tag_q[s] <= wr_tag;
               ppn_q[s] <= wr_ppn;
            end
         end
      end
   endgenerate

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_ppn   = ppn_q[rd_idx];

   // R8: a flush leaves no valid entry behind
   p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));

   // R5: a refill without flush makes its set valid
   p_fill_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/xlat_cache_fsm.sv
module xlat_cache_fsm
   import xlat_cache_pkg::*;
#(
   parameter int VPN_W = 20,
   parameter int OFF_W = 12,
   parameter int PPN_W = 20,
   parameter int IDX_W = 4,
   localparam int TAG_W = VPN_W - IDX_W,
   localparam int PA_W  = PPN_W + OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             req_valid,
   input  logic [VPN_W-1:0] req_vpn,
   input  logic [OFF_W-1:0] req_off,
   output logic             req_ready,
   input  logic             rd_valid,
   input  logic [TAG_W-1:0] rd_tag,
   input  logic [PPN_W-1:0] rd_ppn,
   output logic             fill_en,
   output logic [IDX_W-1:0] fill_idx,
   output logic [TAG_W-1:0] fill_tag,
   output logic             resp_valid,
   output logic             resp_hit,
   output logic             resp_fault,
   output logic [PA_W-1:0]  resp_paddr,
   output logic             walk_req,
   output logic [VPN_W-1:0] walk_vpn,
   input  logic             walk_done,
   input  logic             walk_fault
);
   xc_state_e        state_q;
   logic [VPN_W-1:0] vpn_q;
   logic [OFF_W-1:0] off_q;
   logic             lk_hit;
   logic             take;

   assign take   = req_valid && (state_q == XC_IDLE);
   assign lk_hit = rd_valid && (rd_tag == req_vpn[VPN_W-1:IDX_W]) && !flush;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= XC_IDLE;
         vpn_q      <= '0;
         off_q      <= '0;
         walk_req   <= 1'b0;
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_fault <= 1'b0;
         resp_paddr <= '0;
      end else begin
         resp_valid <= 1'b0;
         unique case (state_q)
            XC_IDLE: begin
               if (take) begin
                  if (lk_hit) begin
                     resp_valid <= 1'b1;
                     resp_hit   <= 1'b1;
                     resp_fault <= 1'b0;
                     resp_paddr <= {rd_ppn, req_off};
                  end else begin
                     state_q  <= XC_WALK;
                     walk_req <= 1'b1;
                     vpn_q    <= req_vpn;
                     off_q    <= req_off;
                  end
               end
            end
            XC_WALK: begin
               if (walk_done) begin
                  state_q    <= XC_IDLE;
                  walk_req   <= 1'b0;
                  resp_valid <= 1'b1;
                  resp_hit   <= 1'b0;
                  resp_fault <= walk_fault;
                  resp_paddr <= {walk_ppn_unused_guard(), off_q};
               end
            end
            default: state_q <= XC_IDLE;
         endcase
      end
   end

   // The page number of a finished walk comes in through the refill path.
   logic [PPN_W-1:0] walk_ppn_in;
   function automatic logic [PPN_W-1:0] walk_ppn_unused_guard();
      return walk_ppn_in;
   endfunction

   assign req_ready = (state_q == XC_IDLE);
   assign walk_vpn  = vpn_q;
   assign fill_en   = (state_q == XC_WALK) && walk_done && !walk_fault;
   assign fill_idx  = vpn_q[IDX_W-1:0];
   assign fill_tag  = vpn_q[VPN_W-1:IDX_W];

   // R2: no new request while a walk is pending
   p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req |-> !req_ready);

   // R3: a hit response never comes with a walk
   p_hit_nowalk_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_hit) |-> !walk_req);

   // R4: walk request and page are held until done
   p_walk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && !walk_done) |=> (walk_req && $stable(walk_vpn)));

   // R5: walk completion yields a non-hit response and drops the request
   p_refill_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && walk_done) |=> (resp_valid && !resp_hit && !walk_req));

   // R6: a fault is never reported as a hit
   p_fault_no_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_fault) |-> !resp_hit);

   // R10: a request taken during flush goes to the walker
   p_flush_lookup_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (take && flush) |=> (walk_req && !resp_valid));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
   parameter int VPN_W = 20,
   parameter int OFF_W = 12,
   parameter int PPN_W = 20,
   parameter int SETS  = 16,
   localparam int IDX_W = $clog2(SETS),
   localparam int TAG_W = VPN_W - IDX_W,
   localparam int VA_W  = VPN_W + OFF_W,
   localparam int PA_W  = PPN_W + OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             req_valid_i,
   input  logic [VA_W-1:0]  req_vaddr_i,
   output logic             req_ready_o,
   output logic             resp_valid_o,
   output logic             resp_hit_o,
   output logic             resp_fault_o,
   output logic [PA_W-1:0]  resp_paddr_o,
   output logic             walk_req_o,
   output logic [VPN_W-1:0] walk_vpn_o,
   input  logic             walk_done_i,
   input  logic             walk_fault_i,
   input  logic [PPN_W-1:0] walk_ppn_i
);
   generate
      if (VPN_W <= IDX_W) begin : g_bad_vpn
         $error("xlat_cache: VPN_W must exceed the index width");
      end
   endgenerate

   logic [VPN_W-1:0] req_vpn;
   logic [OFF_W-1:0] req_off;
   logic             rd_valid;
   logic [TAG_W-1:0] rd_tag;
   logic [PPN_W-1:0] rd_ppn;
   logic             fill_en;
   logic [IDX_W-1:0] fill_idx;
   logic [TAG_W-1:0] fill_tag;

   assign req_vpn = req_vaddr_i[VA_W-1:OFF_W];
   assign req_off = req_vaddr_i[OFF_W-1:0];

   xlat_cache_array #(
      .SETS (SETS),
      .TAG_W(TAG_W),
      .PPN_W(PPN_W)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush_i),
      .rd_idx  (req_vpn[IDX_W-1:0]),
      .rd_valid(rd_valid),
      .rd_tag  (rd_tag),
      .rd_ppn  (rd_ppn),
      .wr_en   (fill_en),
      .wr_idx  (fill_idx),
      .wr_tag  (fill_tag),
      .wr_ppn  (walk_ppn_i)
   );

   xlat_cache_fsm #(
      .VPN_W(VPN_W),
      .OFF_W(OFF_W),
      .PPN_W(PPN_W),
      .IDX_W(IDX_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_i),
      .req_valid (req_valid_i),
      .req_vpn   (req_vpn),
      .req_off   (req_off),
      .req_ready (req_ready_o),
      .rd_valid  (rd_valid),
      .rd_tag    (rd_tag),
      .rd_ppn    (rd_ppn),
      .fill_en   (fill_en),
      .fill_idx  (fill_idx),
      .fill_tag  (fill_tag),
      .resp_valid(resp_valid_o),
      .resp_hit  (resp_hit_o),
      .resp_fault(resp_fault_o),
      .resp_paddr(resp_paddr_o),
      .walk_req  (walk_req_o),
      .walk_vpn  (walk_vpn_o),
      .walk_done (walk_done_i),
      .walk_fault(walk_fault_i)
   );

   assign u_fsm.walk_ppn_in = walk_ppn_i;
endmodule

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_ready;
   logic        resp_valid, resp_hit, resp_fault;
   logic [31:0] resp_paddr;
   logic        walk_req;
   logic [19:0] walk_vpn;
   logic        walk_done = 1'b0;
   logic        walk_fault = 1'b0;
   logic [19:0] walk_ppn = '0;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   xlat_cache dut_i (
      .clk(clk), .rst_n(rst_n), .flush_i(flush),
      .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_ready_o(req_ready),
      .resp_valid_o(resp_valid), .resp_hit_o(resp_hit), .resp_fault_o(resp_fault),
      .resp_paddr_o(resp_paddr), .walk_req_o(walk_req), .walk_vpn_o(walk_vpn),
      .walk_done_i(walk_done), .walk_fault_i(walk_fault), .walk_ppn_i(walk_ppn)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_req(input logic [31:0] va, input bit fl);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; flush = fl;
      @(negedge clk);
      req_valid = 1'b0; flush = 1'b0;
   endtask

   task automatic finish_walk(input logic [19:0] ppn, input bit flt, input bit fl);
      @(negedge clk);
      walk_done = 1'b1; walk_ppn = ppn; walk_fault = flt; flush = fl;
      @(negedge clk);
      walk_done = 1'b0; walk_fault = 1'b0; flush = 1'b0;
   endtask

   task automatic expect_hit(input logic [31:0] va, input logic [31:0] pa, input string req);
      send_req(va, 1'b0);
      chk(resp_valid && resp_hit && !walk_req, req, {resp_valid, resp_hit, walk_req}, 3'b110);
      chk(resp_paddr == pa, req, resp_paddr, pa);
   endtask

   task automatic expect_miss(input logic [31:0] va, input string req);
      send_req(va, 1'b0);
      chk(walk_req && !resp_valid, req, {walk_req, resp_valid}, 2'b10);
      chk(walk_vpn == va[31:12], req, walk_vpn, va[31:12]);
   endtask

   task automatic refill(input logic [19:0] ppn, input logic [11:0] off, input string req);
      finish_walk(ppn, 1'b0, 1'b0);
      chk(resp_valid && !resp_hit && !resp_fault && !walk_req, req,
          {resp_valid, resp_hit, resp_fault, walk_req}, 4'b1000);
      chk(resp_paddr == {ppn, off}, req, resp_paddr, {ppn, off});
   endtask

   task automatic t_reset();
      chk(req_ready && !resp_valid && !walk_req, "R1",
          {req_ready, resp_valid, walk_req}, 3'b100);
   endtask

   task automatic t_cold_miss();
      expect_miss(32'h12345_678, "R1");
      chk(!req_ready, "R2", req_ready, 0);
      repeat (3) @(negedge clk);
      chk(walk_req && walk_vpn == 20'h12345, "R4", walk_vpn, 20'h12345);
      refill(20'hABCDE, 12'h678, "R5");
      chk(req_ready, "R2", req_ready, 1);
      expect_hit(32'h12345_0F0, 32'hABCDE_0F0, "R3");
   endtask

   task automatic t_fault();
      expect_miss(32'h00777_010, "R6");
      finish_walk(20'h11111, 1'b1, 1'b0);
      chk(resp_valid && resp_fault && !resp_hit, "R6",
          {resp_valid, resp_fault, resp_hit}, 3'b110);
      expect_miss(32'h00777_010, "R6");
      refill(20'h22222, 12'h010, "R6");
   endtask

   task automatic t_conflict();
      expect_miss(32'h54325_004, "R7");
      refill(20'h33333, 12'h004, "R7");
      expect_hit(32'h54325_FFF, 32'h33333_FFF, "R7");
      expect_miss(32'h12345_678, "R7");
      refill(20'hABCDE, 12'h678, "R7");
      expect_hit(32'h00777_123, 32'h22222_123, "R7");
   endtask

   task automatic t_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      expect_miss(32'h12345_000, "R8");
      refill(20'hABCDE, 12'h000, "R8");
      expect_miss(32'h00777_000, "R8");
      refill(20'h22222, 12'h000, "R8");
   endtask

   task automatic t_flush_refill();
      expect_miss(32'h0AAA3_456, "R9");
      finish_walk(20'h44444, 1'b0, 1'b1);
      chk(resp_valid && !resp_hit && resp_paddr == 32'h44444_456, "R9",
          resp_paddr, 32'h44444_456);
      expect_miss(32'h0AAA3_456, "R9");
      refill(20'h44444, 12'h456, "R9");
      expect_hit(32'h0AAA3_001, 32'h44444_001, "R9");
   endtask

   task automatic t_flush_lookup();
      send_req(32'h0AAA3_222, 1'b1);
      chk(walk_req && !resp_valid, "R10", {walk_req, resp_valid}, 2'b10);
      refill(20'h55555, 12'h222, "R10");
      expect_hit(32'h0AAA3_333, 32'h55555_333, "R10");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cold_miss();
      t_fault();
      t_conflict();
      t_flush();
      t_flush_refill();
      t_flush_lookup();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #50000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule